// File: doc/BRIEF.md
# Liveness-to-Safety Loop Detector

This block is a synthesizable monitor placed next to a design under observation. It turns a liveness check of the form "the property signal must eventually go low" into a safety flag. A free oracle input picks the cycle in which a copy of the observed state vector is taken into shadow registers. After that, the monitor compares the live state with the copy in every cycle. When the state comes back to the copy, a closed loop of states has been found.

The witness output reports a loop in which the property never went low. It also requires that each fairness condition held at least once while the loop was being traced. A formal engine can drive the oracle freely. The witness then states that there is a fair execution in which the property stays high forever. A bench can also drive the oracle explicitly to exercise a chosen loop.

Sticky flags record the property's history since reset and each fairness condition seen inside the loop. The witness is registered, so it appears one clock after the cycle that closes the loop.

Top module: `l2s_loop_monitor`

## Requirements
- R1: After a synchronous active-high reset, `witness_o` is 0 and every internal register (armed flag, shadow copies, fairness flags, history flag) is cleared.
- R2: The snapshot is taken only in the first cycle after reset in which `oracle_i` is 1. Later oracle pulses change neither the shadow copy nor the armed flag.
- R3: A loop is closed only when every one of the `NUM_REGS` state words equals its shadow word. A mismatch in any single word prevents the witness. State word k occupies bits `[k*REG_W +: REG_W]` of `state_i`.
- R4: The witness requires `prop_i` to be 1 in the cycle that closes the loop.
- R5: Once `prop_i` has been 0 in any cycle since reset, before or after the snapshot, the witness stays 0 until the next reset.
- R6: Each fairness bit `fair_i[j]` counts only when it is 1 in the snapshot cycle or a later cycle. The witness needs every such flag to be already set before the closing cycle. A fairness bit that is first seen in the closing cycle enables the witness one cycle later, provided the loop is still closed.
- R7: `witness_o` is registered. It rises at the clock edge that ends the cycle whose inputs satisfy R3 to R6.
- R8: Before the snapshot has been taken, the witness stays 0, even when the live state equals the cleared shadow contents.
- R9: The witness repeats in every cycle in which the conditions keep holding, and it drops in the first cycle in which the state leaves the snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state_i | input | NUM_REGS*REG_W | Observed state vector; word k at bits [k*REG_W +: REG_W] |
| oracle_i | input | 1 | Nondeterministic request to take the snapshot |
| prop_i | input | 1 | Property signal that must eventually fall |
| fair_i | input | NUM_FAIR | Fairness conditions, one bit each |
| witness_o | output | 1 | Registered flag: fair closed loop with property always high |

## Verification
The witness is the only result, and it is due one clock after the cycle whose inputs close the loop. This also holds for the snapshot cycle and for a fairness bit first seen in the closing cycle; in that second case the witness follows one further cycle later. The driver applies one set of inputs per cycle on the falling edge and queues the expected witness for that cycle. The monitor pops the queue just after the next rising edge, so each expectation is compared with exactly the register value produced by the inputs it belongs to.

// File: rtl/l2s_pkg.sv
package l2s_pkg;
  localparam int DEF_NUM_REGS = 4;
  localparam int DEF_REG_W    = 8;
  localparam int DEF_NUM_FAIR = 2;
endpackage

// File: rtl/l2s_snapshot_ctrl.sv
module l2s_snapshot_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic oracle_i,
  output logic armed_o,
  output logic capture_o,
  output logic in_loop_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else     armed_q <= armed_q | oracle_i;
  end

  assign capture_o = oracle_i & ~armed_q;
  assign in_loop_o = capture_o | armed_q;
  assign armed_o   = armed_q;
endmodule

// File: rtl/l2s_shadow_bank.sv
module l2s_shadow_bank #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  localparam int VEC_W   = NUM_REGS * REG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture_i,
  input  logic [VEC_W-1:0]    state_i,
  output logic [NUM_REGS-1:0] match_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    logic [REG_W-1:0] copy_q;
    logic [REG_W-1:0] live;

    assign live = state_i[k*REG_W +: REG_W];

    always_ff @(posedge clk) begin
      if (rst)            copy_q <= '0;
      else if (capture_i) copy_q <= live;
    end

    assign match_o[k] = (live == copy_q);
  end
endmodule

// File: rtl/l2s_sticky_flags.sv
module l2s_sticky_flags #(
  parameter int NUM_FAIR = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_loop_i,
  input  logic [NUM_FAIR-1:0] fair_i,
  input  logic                prop_i,
  output logic [NUM_FAIR-1:0] fair_seen_o,
  output logic                prop_fell_o
);
  for (genvar j = 0; j < NUM_FAIR; j++) begin : g_fair
    logic seen_q;
    always_ff @(posedge clk) begin
      if (rst) seen_q <= 1'b0;
      else     seen_q <= seen_q | (fair_i[j] & in_loop_i);
    end
    assign fair_seen_o[j] = seen_q;
  end

  logic fell_q;
  always_ff @(posedge clk) begin
    if (rst) fell_q <= 1'b0;
    else     fell_q <= fell_q | ~prop_i;
  end
  assign prop_fell_o = fell_q;
endmodule

// File: rtl/l2s_loop_monitor.sv
module l2s_loop_monitor #(
  parameter int NUM_REGS = l2s_pkg::DEF_NUM_REGS,
  parameter int REG_W    = l2s_pkg::DEF_REG_W,
  parameter int NUM_FAIR = l2s_pkg::DEF_NUM_FAIR,
  localparam int VEC_W   = NUM_REGS * REG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [VEC_W-1:0]    state_i,
  input  logic                oracle_i,
  input  logic                prop_i,
  input  logic [NUM_FAIR-1:0] fair_i,
  output logic                witness_o
);
  logic                armed;
  logic                capture;
  logic                in_loop;
  logic [NUM_REGS-1:0] match;
  logic [NUM_FAIR-1:0] fair_seen;
  logic                prop_fell;
  logic                loop_closed;
  logic                witness_d;
  logic                witness_q;

  l2s_snapshot_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .oracle_i  (oracle_i),
    .armed_o   (armed),
    .capture_o (capture),
    .in_loop_o (in_loop)
  );

  l2s_shadow_bank #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .capture_i (capture),
    .state_i   (state_i),
    .match_o   (match)
  );

  l2s_sticky_flags #(
    .NUM_FAIR (NUM_FAIR)
  ) u_flags (
    .clk         (clk),
    .rst         (rst),
    .in_loop_i   (in_loop),
    .fair_i      (fair_i),
    .prop_i      (prop_i),
    .fair_seen_o (fair_seen),
    .prop_fell_o (prop_fell)
  );

  assign loop_closed = armed & (&match);
  assign witness_d   = loop_closed & prop_i & ~prop_fell & (&fair_seen);

  always_ff @(posedge clk) begin
    if (rst) witness_q <= 1'b0;
    else     witness_q <= witness_d;
  end

  assign witness_o = witness_q;
endmodule

// File: rtl/l2s_loop_monitor_chk.sv
module l2s_loop_monitor_chk #(
  parameter int NUM_FAIR = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                prop_i,
  input logic                witness_o,
  input logic                armed,
  input logic                capture,
  input logic                loop_closed,
  input logic                prop_fell,
  input logic [NUM_FAIR-1:0] fair_seen
);
  assert_armed_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  assert_capture_once_R2: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture);

  assert_needs_closed_loop_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(witness_o) |-> $past(loop_closed));

  assert_needs_prop_high_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(witness_o) |-> $past(prop_i));

  assert_history_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    prop_fell |=> !witness_o);

  assert_needs_fairness_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(witness_o) |-> $past(&fair_seen));

  assert_no_witness_unarmed_R8: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !witness_o);
endmodule

bind l2s_loop_monitor l2s_loop_monitor_chk #(.NUM_FAIR(NUM_FAIR)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .prop_i      (prop_i),
  .witness_o   (witness_o),
  .armed       (armed),
  .capture     (capture),
  .loop_closed (loop_closed),
  .prop_fell   (prop_fell),
  .fair_seen   (fair_seen)
);

// File: tb/sim_l2s_loop_monitor.sv
`timescale 1ns/1ps
module sim_l2s_loop_monitor;
  localparam int NUM_REGS = 4;
  localparam int REG_W    = 8;
  localparam int NUM_FAIR = 2;
  localparam int VEC_W    = NUM_REGS * REG_W;

  localparam logic [VEC_W-1:0] ST_A = 32'h11223344;
  localparam logic [VEC_W-1:0] ST_B = 32'h55667788;
  localparam logic [VEC_W-1:0] ST_C = 32'h0badf00d;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [VEC_W-1:0]    state_i = '0;
  logic                oracle_i = 1'b0;
  logic                prop_i = 1'b1;
  logic [NUM_FAIR-1:0] fair_i = '0;
  logic                witness_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #5 clk = ~clk;

  l2s_loop_monitor #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .NUM_FAIR (NUM_FAIR)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .state_i   (state_i),
    .oracle_i  (oracle_i),
    .prop_i    (prop_i),
    .fair_i    (fair_i),
    .witness_o (witness_o)
  );

  // Monitor: compares the witness produced by each driven cycle.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (witness_o !== it.exp) begin
        failures++;
        $display("FAIL %s witness=%0b expected=%0b", it.tag, witness_o, it.exp);
      end
    end
  end

  task automatic step(input logic [VEC_W-1:0] st, input logic orc,
                      input logic prp, input logic [NUM_FAIR-1:0] fr,
                      input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    state_i  = st;
    oracle_i = orc;
    prop_i   = prp;
    fair_i   = fr;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic do_reset();
    item_t it;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      rst      = 1'b1;
      state_i  = '0;
      oracle_i = 1'b0;
      prop_i   = 1'b1;
      fair_i   = '0;
      it.exp = 1'b0;
      it.tag = "R1 reset";
      sb.push_back(it);
    end
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    sb.delete();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);

    // Basic loop: snapshot, leave, return (R2 R7 R9)
    do_reset();
    step(ST_A, 1, 1, 2'b11, 0, "R7 snapshot cycle");
    step(ST_B, 0, 1, 2'b00, 0, "R3 away from snapshot");
    step(ST_A, 0, 1, 2'b00, 1, "R7 loop closed");
    step(ST_A, 0, 1, 2'b00, 1, "R9 still closed");
    step(ST_B, 0, 1, 2'b00, 0, "R9 left loop");

    // Property fell inside the loop (R5)
    do_reset();
    step(ST_A, 1, 1, 2'b11, 0, "R5 snapshot");
    step(ST_B, 0, 0, 2'b00, 0, "R5 prop low");
    step(ST_A, 0, 1, 2'b00, 0, "R5 history blocks");

    // Property fell before the snapshot (R5)
    do_reset();
    step(ST_C, 0, 0, 2'b00, 0, "R5 early low");
    step(ST_A, 1, 1, 2'b11, 0, "R5 snapshot late");
    step(ST_A, 0, 1, 2'b00, 0, "R5 early history blocks");

    // Property low in the closing cycle (R4)
    do_reset();
    step(ST_A, 1, 1, 2'b11, 0, "R4 snapshot");
    step(ST_A, 0, 0, 2'b00, 0, "R4 prop low at closure");
    step(ST_A, 0, 1, 2'b00, 0, "R5 blocked after low");

    // Fairness (R6)
    do_reset();
    step(ST_A, 0, 1, 2'b11, 0, "R6 fair before snapshot");
    step(ST_A, 1, 1, 2'b01, 0, "R6 snapshot with f0");
    step(ST_B, 0, 1, 2'b00, 0, "R6 away");
    step(ST_A, 0, 1, 2'b00, 0, "R6 unfair loop");
    step(ST_A, 0, 1, 2'b10, 0, "R6 f1 in closing cycle");
    step(ST_A, 0, 1, 2'b00, 1, "R6 fair next cycle");

    // Partial match (R3)
    do_reset();
    step(ST_A, 1, 1, 2'b11, 0, "R3 snapshot");
    step(ST_A ^ 32'h00000100, 0, 1, 2'b00, 0, "R3 word1 differs");
    step(ST_A ^ 32'h01000000, 0, 1, 2'b00, 0, "R3 word3 differs");
    step(ST_A ^ 32'h00000001, 0, 1, 2'b00, 0, "R3 word0 differs");
    step(ST_A, 0, 1, 2'b00, 1, "R3 full match");

    // Second oracle pulse ignored (R2)
    do_reset();
    step(ST_A, 1, 1, 2'b11, 0, "R2 first snapshot");
    step(ST_B, 1, 1, 2'b00, 0, "R2 second oracle");
    step(ST_B, 0, 1, 2'b00, 0, "R2 no resnapshot");
    step(ST_A, 0, 1, 2'b00, 1, "R2 original snapshot kept");

    // No snapshot taken (R8)
    do_reset();
    step('0, 0, 1, 2'b11, 0, "R8 zero state unarmed");
    step('0, 0, 1, 2'b00, 0, "R8 still unarmed");

    step('0, 0, 1, 2'b00, 0, "R8 tail");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule